// File: doc/BRIEF.md
# Pipelined Byte-Writable Synchronous SRAM

This block is a single-port synchronous static RAM that stores 32-bit words as four 8-bit lanes. The first rising clock edge of an access registers the address, write data and write controls. The second rising edge performs the access. A write can change any subset of the lanes. A read loads the addressed word into an output register, so the data reaches the output pin two edges after the address was applied, and no combinational path runs from the array to the pin.

Lane selection uses three kinds of active-low input. There is one enable per lane. These enables count only while a separate lane-write qualifier is low. A global write input, when low, stores the whole word whatever the lane enables show. Any registered cycle that writes no lane is a read. A sleep input, sampled with the other inputs, cancels the access of that cycle: no lane is written, the array keeps its contents and the output register keeps its value. The depth is 2**ADDR_W words. ADDR_W = 16 gives the full 65,536-word array, and the default is kept small so that simulation stays light.

Top module: `sync_pipe_sram`

## Requirements
- R1: While rst_n is low, dout is 0. After reset and before any access, no lane is written.
- R2: When a read is applied before rising edge k (gw_n high, and bwe_n high or bw_n all ones, zz low), dout shows the addressed word after edge k+1 and keeps it until the next read updates it.
- R3: With gw_n high and bwe_n low, a low bw_n[i] writes din bits 8i+7:8i into the addressed word. Lanes whose bw_n bit is high keep their old bytes.
- R4: With gw_n high and bwe_n high, bw_n has no effect. The cycle is a read and no lane is written.
- R5: A low gw_n writes all four lanes, whatever the levels of bwe_n and bw_n.
- R6: A cycle with zz high writes nothing. All stored words keep their values.
- R7: A cycle with zz high does not update dout. The output keeps its previous value.
- R8: A read applied in the cycle right after a write to the same address returns the newly written bytes merged with the lanes that were left unwritten.
- R9: A cycle that writes at least one lane leaves dout unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline registers |
| addr | input | ADDR_W | Word address |
| din | input | 32 | Write data, lane i in bits 8i+7:8i |
| gw_n | input | 1 | Global write, active low, writes all lanes |
| bwe_n | input | 1 | Lane-write qualifier, active low |
| bw_n | input | 4 | Per-lane write enables, active low, bit i selects lane i |
| zz | input | 1 | Sleep, active high, cancels the access of the cycle |
| dout | output | 32 | Registered read data |

## Verification
The inputs of a cycle are registered at edge k. A write reaches the array at edge k+1. A read reaches dout at edge k+1, which is two edges after the address was applied. The bench drives its stimulus on falling edges and keeps a behavioural model that follows this schedule. The model holds a queue of captured cycles, applies each one a full edge after capture, and compares dout with the model's output on every falling edge. Checks therefore never fall on an edge where the output is changing. Hold cases (sleep cycles and write cycles) and back-to-back write-then-read to one address are covered by this same per-cycle comparison.

// File: rtl/sync_pipe_sram.sv
module sync_pipe_sram #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [8*LANES-1:0]   din,
  input  logic                 gw_n,
  input  logic                 bwe_n,
  input  logic [LANES-1:0]     bw_n,
  input  logic                 zz,
  output logic [8*LANES-1:0]   dout
);
  localparam int DW    = 8 * LANES;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0]     mem [DEPTH];
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     din_q;
  logic [LANES-1:0]  wmask_q;
  logic              rd_q;

  wire [LANES-1:0] lane_sel = !gw_n ? {LANES{1'b1}} : (!bwe_n ? ~bw_n : '0);
  wire [LANES-1:0] wmask_d  = zz ? '0 : lane_sel;
  wire             rd_d     = !zz && (lane_sel == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      din_q   <= '0;
      wmask_q <= '0;
      rd_q    <= 1'b0;
    end else begin
      addr_q  <= addr;
      din_q   <= din;
      wmask_q <= wmask_d;
      rd_q    <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (wmask_q[i]) mem[addr_q][8*i +: 8] <= din_q[8*i +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dout <= '0;
    else if (rd_q) dout <= mem[addr_q];
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |-> (wmask_q == '0 && !rd_q)); // R1
  AST_LANE_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && gw_n && !bwe_n) |=> (wmask_q == ~$past(bw_n))); // R3
  AST_QUAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (gw_n && bwe_n) |=> (wmask_q == '0)); // R4
  AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && !gw_n) |=> (wmask_q == {LANES{1'b1}})); // R5
  AST_SLEEP_NOWR: assert property (@(posedge clk) disable iff (!rst_n)
    zz |=> (wmask_q == '0)); // R6
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    zz |=> ##1 $stable(dout)); // R7
  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && (!gw_n || (!bwe_n && bw_n != {LANES{1'b1}}))) |=> ##1 $stable(dout)); // R9
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_q && wmask_q != '0)); // R2
endmodule

// File: tb/sync_pipe_sram_bench.sv
`timescale 1ns/1ps
module sync_pipe_sram_bench;
  localparam int AW = 6;
  localparam int NW = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] din = '0;
  logic gw_n = 1, bwe_n = 1, zz = 0;
  logic [3:0] bw_n = 4'hF;
  logic [31:0] dout;
  string tag = "R1";

  int compared = 0, mismatched = 0;

  sync_pipe_sram #(.ADDR_W(AW), .LANES(4)) u_sync_pipe_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .zz(zz), .dout(dout));

  always #4 clk = ~clk;

  typedef struct { int a; logic [31:0] d; logic [3:0] m; bit rd; string t; } acc_t;
  logic [31:0] ref_mem [NW];
  acc_t pend[$];
  logic [31:0] exp_out = '0;
  string exp_tag = "R1";

  always @(posedge clk) begin
    acc_t c;
    logic [3:0] m;
    if (!rst_n) begin
      pend.delete();
      exp_out = '0;
    end else begin
      if (pend.size() > 0) begin
        c = pend.pop_front();
        exp_tag = c.t;
        if (c.rd) exp_out = ref_mem[c.a];
        for (int i = 0; i < 4; i++)
          if (c.m[i]) ref_mem[c.a][8*i +: 8] = c.d[8*i +: 8];
      end
      if (zz) m = 4'h0;
      else if (!gw_n) m = 4'hF;
      else if (!bwe_n) m = ~bw_n;
      else m = 4'h0;
      c.a = int'(addr); c.d = din; c.m = m; c.t = tag;
      c.rd = !zz && (m == 4'h0);
      pend.push_back(c);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      compared++;
      if (dout !== exp_out) begin
        mismatched++;
        $display("FAIL %s actual=%h expected=%h at %0t", exp_tag, dout, exp_out, $time);
      end
    end
  end

  task automatic cyc(input int a, input logic [31:0] d, input logic g,
                     input logic q, input logic [3:0] b, input logic z, input string t);
    @(negedge clk);
    addr = a[AW-1:0]; din = d; gw_n = g; bwe_n = q; bw_n = b; zz = z; tag = t;
  endtask

  task automatic rd(input int a, input string t);
    cyc(a, 32'hDEAD_BEEF, 1'b1, 1'b1, 4'h0, 1'b0, t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compared++;
    if (dout !== 32'h0) begin
      mismatched++;
      $display("FAIL R1 actual=%h expected=%h", dout, 32'h0);
    end
    @(negedge clk) rst_n = 1;
    for (int i = 0; i < NW; i++)
      cyc(i, (i * 32'h0101_0101) ^ 32'hA500_3C00, 1'b0, 1'b1, 4'hF, 1'b0, "R5");
    for (int i = 0; i < 8; i++) rd(i * 7, "R2");
    for (int i = 0; i < 4; i++) begin
      cyc(10 + i, 32'h1122_3344 + i, 1'b1, 1'b0, ~(4'h1 << i), 1'b0, "R3");
      rd(10 + i, "R3");
    end
    cyc(20, 32'hFFFF_FFFF, 1'b1, 1'b1, 4'h0, 1'b0, "R4");
    rd(20, "R4");
    cyc(21, 32'h7777_8888, 1'b0, 1'b1, 4'hF, 1'b0, "R5");
    rd(21, "R5");
    rd(3, "R7");
    cyc(22, 32'h0BAD_F00D, 1'b0, 1'b0, 4'h0, 1'b1, "R6");
    cyc(23, 32'h0BAD_F00D, 1'b1, 1'b1, 4'h0, 1'b1, "R7");
    cyc(24, 32'h0, 1'b1, 1'b1, 4'h0, 1'b1, "R7");
    rd(22, "R6");
    rd(5, "R9");
    cyc(30, 32'hCAFE_0001, 1'b1, 1'b0, 4'hA, 1'b0, "R9");
    cyc(31, 32'hCAFE_0002, 1'b0, 1'b1, 4'hF, 1'b0, "R9");
    cyc(32, 32'hABCD_1234, 1'b1, 1'b0, 4'h5, 1'b0, "R8");
    rd(32, "R8");
    cyc(33, 32'h5555_AAAA, 1'b0, 1'b0, 4'h3, 1'b0, "R8");
    rd(33, "R8");
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 9);
      cyc($urandom_range(0, NW - 1), $urandom, r < 2 ? 1'b0 : 1'b1,
          r < 5 ? 1'b0 : 1'b1, 4'($urandom_range(0, 15)), r == 9, "R2");
    end
    repeat (3) rd(0, "R2");
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL R2 actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule